// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Port

This block controls a bank of general-purpose pins (16 by default) through a small register interface. Software sets each pin as a driver or a receiver. A driven pin's level can be loaded as a whole word, or changed bit by bit through a write-one-to-raise register and a write-one-to-lower register. A receiving pin is looked at only when its input-enable bit is set. Its external level then goes through a two-stage synchroniser, an optional inversion, and either a level path or a sticky rising-edge catcher.

The resulting per-pin status word can be read back. It also feeds two interrupt request lines. Each line is the OR, over all pins, of the status bit ANDed with that line's own mask register. The interrupt controller, priority handling and pin sharing with other functions all live outside this block.

The register interface has one write strobe and an address. Reads are combinational from the address. A write takes effect at the clock edge that samples it.

Top module: `gpio_irq_port`

## Requirements
- R1: While reset is asserted, all configuration registers and all status bits are zero. Every pin is an input, `pin_oe` is 0, both interrupt lines are low and a status read returns 0.
- R2: `pin_oe[i]` equals direction bit i (1 = drive, 0 = receive), and `pin_out[i]` equals status bit i.
- R3: For a driven pin, writing address 1 with bit i at 1 makes status bit i 1, and writing address 2 with bit i at 1 makes it 0. Bits written as 0 leave their pins unchanged.
- R4: Writing address 0 loads the written bits into the status of driven pins only. The status of receiving pins is not changed by writes to address 0 or address 1.
- R5: A receiving pin whose input-enable bit is 0 keeps status 0, whatever its external level.
- R6: A receiving, enabled pin with edge bit 0 (level mode) shows its sensed level in status. A change at `pin_in` appears after the third rising clock edge and not after the second.
- R7: A receiving, enabled pin with edge bit 1 sets its status on a 0-to-1 transition of the sensed level. The bit stays set after the level falls, until address 2 is written with that bit at 1.
- R8: A polarity bit of 1 inverts the sensed level of its pin (active-low). A polarity bit of 0 leaves it active-high.
- R9: `irq_a` is the OR over pins of status AND mask A. `irq_b` is the same with mask B. Both follow the status with no added delay.
- R10: Address map: 0 status, 1 raise, 2 lower, 3 direction, 4 input enable, 5 mask A, 6 mask B, 7 edge select, 8 polarity. Registers 3 to 8 read back what was written. Addresses 1 and 2, and any unmapped address, read 0.
- R11: If a rising edge is caught in the same cycle as a clearing write to that bit, the bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for reads and writes |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| pin_in | input | 16 | External pin levels |
| pin_out | output | 16 | Levels driven to the pins |
| pin_oe | output | 16 | Per-pin drive enable |
| irq_a | output | 1 | Interrupt request A |
| irq_b | output | 1 | Interrupt request B |

## Verification
Register writes and direct output changes are visible at the first falling edge after the edge that captures the write, because reads and `pin_out` come straight from registers. Pin-driven status has three registers on its path: two synchroniser stages and the status flop. The bench changes `pin_in` on a falling edge and samples once after the second rising edge, expecting the old value, then again after the third, expecting the new one. The interrupt lines are checked in the same sampling slot as the status they depend on. The clear-versus-edge race is forced by issuing the clearing write in exactly the cycle in which the second synchroniser stage first shows the new level.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int PIN_COUNT = 16;
  localparam int ADDR_W    = 4;

  localparam logic [ADDR_W-1:0] RA_STAT = 4'd0;
  localparam logic [ADDR_W-1:0] RA_RAIS = 4'd1;
  localparam logic [ADDR_W-1:0] RA_LOWR = 4'd2;
  localparam logic [ADDR_W-1:0] RA_DIR  = 4'd3;
  localparam logic [ADDR_W-1:0] RA_INEN = 4'd4;
  localparam logic [ADDR_W-1:0] RA_MSKA = 4'd5;
  localparam logic [ADDR_W-1:0] RA_MSKB = 4'd6;
  localparam logic [ADDR_W-1:0] RA_EDGE = 4'd7;
  localparam logic [ADDR_W-1:0] RA_POL  = 4'd8;
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      q_o      <= '0;
    end else begin
      stage1_q <= d_i;
      q_o      <= stage1_q;
    end
  end
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_irq_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      dir_o,
  output logic [N-1:0]      inen_o,
  output logic [N-1:0]      mska_o,
  output logic [N-1:0]      mskb_o,
  output logic [N-1:0]      edge_o,
  output logic [N-1:0]      pol_o,
  output logic              stat_we_o,
  output logic              rais_we_o,
  output logic              lowr_we_o
);
  logic dir_en, inen_en, mska_en, mskb_en, edge_en, pol_en;

  always_comb begin
    dir_en    = wr_en && (addr == RA_DIR);
    inen_en   = wr_en && (addr == RA_INEN);
    mska_en   = wr_en && (addr == RA_MSKA);
    mskb_en   = wr_en && (addr == RA_MSKB);
    edge_en   = wr_en && (addr == RA_EDGE);
    pol_en    = wr_en && (addr == RA_POL);
    stat_we_o = wr_en && (addr == RA_STAT);
    rais_we_o = wr_en && (addr == RA_RAIS);
    lowr_we_o = wr_en && (addr == RA_LOWR);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_o  <= '0;
      inen_o <= '0;
      mska_o <= '0;
      mskb_o <= '0;
      edge_o <= '0;
      pol_o  <= '0;
    end else begin
      if (dir_en)  dir_o  <= wdata;
      if (inen_en) inen_o <= wdata;
      if (mska_en) mska_o <= wdata;
      if (mskb_en) mskb_o <= wdata;
      if (edge_en) edge_o <= wdata;
      if (pol_en)  pol_o  <= wdata;
    end
  end

  // R10: a configuration write is held until the next write to it
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_en |=> $stable(dir_o));
endmodule

// File: rtl/gpio_flag_cell.sv
module gpio_flag_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic dir_i,
  input  logic inen_i,
  input  logic edge_i,
  input  logic pol_i,
  input  logic pin_sync_i,
  input  logic stat_we_i,
  input  logic stat_bit_i,
  input  logic rais_hit_i,
  input  logic lowr_hit_i,
  output logic flag_o
);
  logic sensed, sensed_q, rise, flag_d;

  always_comb begin
    sensed = inen_i & (pin_sync_i ^ pol_i);
    rise   = sensed & ~sensed_q;
    flag_d = flag_o;
    if (dir_i) begin
      if (stat_we_i)       flag_d = stat_bit_i;
      else if (rais_hit_i) flag_d = 1'b1;
      else if (lowr_hit_i) flag_d = 1'b0;
    end else if (edge_i) begin
      flag_d = rise | (flag_o & ~lowr_hit_i);
    end else begin
      flag_d = sensed;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o   <= 1'b0;
      sensed_q <= 1'b0;
    end else begin
      flag_o   <= flag_d;
      sensed_q <= sensed;
    end
  end

  // R5: a disabled receiving pin never gains a status bit
  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_i && !inen_i && !flag_o) |=> !flag_o);
  // R6: level mode copies the sensed level one edge later
  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_i && !edge_i) |=> (flag_o == $past(sensed)));
  // R7: a caught edge stays set until cleared
  assert_edge_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_i && edge_i && flag_o && !lowr_hit_i) |=> flag_o);
  // R11: a rising edge wins over a simultaneous clear
  assert_rise_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_i && edge_i && rise) |=> flag_o);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int N_PINS = PIN_COUNT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N_PINS-1:0] wdata,
  output logic [N_PINS-1:0] rdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_a,
  output logic              irq_b
);
  logic [N_PINS-1:0] dir_q, inen_q, mska_q, mskb_q, edge_q, pol_q;
  logic [N_PINS-1:0] pin_sync, flags;
  logic              stat_we, rais_we, lowr_we;

  gpio_sync2 #(.W(N_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_in), .q_o(pin_sync)
  );

  gpio_cfg_regs #(.N(N_PINS)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .dir_o(dir_q), .inen_o(inen_q), .mska_o(mska_q), .mskb_o(mskb_q),
    .edge_o(edge_q), .pol_o(pol_q),
    .stat_we_o(stat_we), .rais_we_o(rais_we), .lowr_we_o(lowr_we)
  );

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    gpio_flag_cell u_cell (
      .clk(clk), .rst_n(rst_n),
      .dir_i(dir_q[i]), .inen_i(inen_q[i]), .edge_i(edge_q[i]), .pol_i(pol_q[i]),
      .pin_sync_i(pin_sync[i]),
      .stat_we_i(stat_we), .stat_bit_i(wdata[i]),
      .rais_hit_i(rais_we & wdata[i]), .lowr_hit_i(lowr_we & wdata[i]),
      .flag_o(flags[i])
    );
  end

  assign pin_out = flags;
  assign pin_oe  = dir_q;
  assign irq_a   = |(flags & mska_q);
  assign irq_b   = |(flags & mskb_q);

  always_comb begin
    case (addr)
      RA_STAT: rdata = flags;
      RA_DIR:  rdata = dir_q;
      RA_INEN: rdata = inen_q;
      RA_MSKA: rdata = mska_q;
      RA_MSKB: rdata = mskb_q;
      RA_EDGE: rdata = edge_q;
      RA_POL:  rdata = pol_q;
      default: rdata = '0;
    endcase
  end

  // R3: a raise write sets every driven pin it names
  assert_raise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_RAIS) |=>
      ((pin_out & $past(wdata & dir_q)) == $past(wdata & dir_q)));
  // R3: a lower write clears every driven pin it names
  assert_lower_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_LOWR) |=> ((pin_out & $past(wdata & dir_q)) == '0));
  // R4: a status write cannot touch receiving pins held disabled
  assert_stat_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RA_STAT && edge_q == '1 && flags == '0 && inen_q == '0)
      |=> ((flags & ~$past(dir_q)) == '0));
  // R9: no request without a masked status bit
  assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flags == '0) |-> (!irq_a && !irq_b));
endmodule

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic [15:0] pin_in = 16'h0;
  logic [15:0] pin_out, pin_oe;
  logic        irq_a, irq_b;
  int          errors = 0;
  int          checks = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  typedef struct packed {
    logic [3:0]  wa;
    logic [15:0] wd;
    logic [3:0]  ra;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{4'd3, 16'h00FF, 4'd3, 16'h00FF},  // R10 direction readback
    '{4'd0, 16'hA5A5, 4'd0, 16'h00A5},  // R4 receiving bits untouched
    '{4'd1, 16'h0F0F, 4'd0, 16'h00AF},  // R3 raise, zero bits kept
    '{4'd2, 16'h0081, 4'd0, 16'h002E},  // R3 lower, zero bits kept
    '{4'd5, 16'h0002, 4'd5, 16'h0002},  // R10 mask A
    '{4'd6, 16'h1000, 4'd6, 16'h1000},  // R10 mask B
    '{4'd7, 16'hF000, 4'd7, 16'hF000},  // R10 edge select
    '{4'd8, 16'h0F00, 4'd8, 16'h0F00},  // R10 polarity
    '{4'd1, 16'hFFFF, 4'd1, 16'h0000},  // R10 raise reads 0
    '{4'd12, 16'hFFFF, 4'd12, 16'h0000} // R10 unmapped reads 0
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    rd(4'd3, v); check("R1 dir", v, 16'h0);
    check("R1 oe", pin_oe, 16'h0);
    check("R1 irq", {14'h0, irq_a, irq_b}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 10; k++) begin
      wr(VECS[k].wa, VECS[k].wd);
      rd(VECS[k].ra, v);
      check($sformatf("R10/R3/R4 row %0d", k), v, VECS[k].exp);
    end

    // R2 pin outputs follow direction and status
    check("R2 oe", pin_oe, 16'h00FF);
    check("R2 out", pin_out, 16'h00FF);
    // R9 mask A bit 1 is set on a driven pin
    check("R9 irq after table", {14'h0, irq_a, irq_b}, 16'h0002);

    // R5 disabled receivers stay 0
    pin_in = 16'hFFFF;
    repeat (5) @(negedge clk);
    rd(4'd0, v); check("R5 disabled", v, 16'h00FF);

    // R7 enabling edge pins with high input catches an edge; R8 inverted pins read 0
    wr(4'd4, 16'hFF00);
    repeat (4) @(negedge clk);
    rd(4'd0, v); check("R7/R8 enable", v, 16'hF0FF);
    check("R9 irq b set", {14'h0, irq_a, irq_b}, 16'h0003);

    // R6 latency with R8 active-low sensing
    pin_in = 16'hF0FF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rd(4'd0, v); check("R6 not after 2 edges", v, 16'hF0FF);
    @(negedge clk);
    rd(4'd0, v); check("R6/R8 after 3 edges", v, 16'hFFFF);

    // R7 sticky after input falls
    pin_in = 16'h00FF;
    repeat (4) @(negedge clk);
    rd(4'd0, v); check("R7 sticky", v, 16'hFFFF);
    wr(4'd2, 16'h1000);
    rd(4'd0, v); check("R7 clear", v, 16'hEFFF);
    check("R9 irq b cleared", {14'h0, irq_a, irq_b}, 16'h0002);

    // R11 clear in the cycle of a caught edge
    wr(4'd2, 16'h2000);
    rd(4'd0, v); check("R11 pre-clear", v, 16'hCFFF);
    pin_in = 16'h20FF;
    @(posedge clk); @(posedge clk); @(negedge clk);
    wr(4'd2, 16'h2000);
    rd(4'd0, v); check("R11 rise wins", v, 16'hEFFF);

    // R1 reset mid-run
    rst_n = 1'b0;
    #0.5;
    rd(4'd0, v); check("R1 status", v, 16'h0);
    check("R1 oe again", pin_oe, 16'h0);
    check("R1 irq again", {14'h0, irq_a, irq_b}, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule